// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands in pure combinational logic. Every operand bit is fanned out to each cell that needs it, and an AND gate per cell forms a partial product bit. Rows of half-adder and full-adder cells then reduce those bits. A cell's carry is not passed sideways to its neighbour. It drops into the next row at the next higher weight, so no row holds a horizontal carry chain. Each row settles one more low product bit. The sum and carry vectors left after the last row go into a single ripple adder that produces the upper half of the product.

The operand widths are parameters. The default is 4 by 4, giving an 8-bit product. There is no clock, no state and no reset. The result follows the operands after the settling time of the array plus the merge adder. A datapath instantiates the block wherever it needs a small, regular, area-lean unsigned multiply.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals `mcand_i * mplier_i`, and the product is MW+NW bits wide (8 bits by default).
- R2: If either operand is zero, `prod_o` is zero.
- R3: Product bit 0 equals `mcand_i[0] & mplier_i[0]`.
- R4: A multiplier value of 1 returns the multiplicand unchanged on the low bits, with zeros above. A multiplicand of 1 likewise returns the multiplier.
- R5: A multiplier equal to 2^k returns the multiplicand shifted left by k places, because each partial product bit `mcand_i[i] & mplier_i[j]` has weight 2^(i+j).
- R6: The all-ones operands give the largest product, (2^MW-1)(2^NW-1), which is 225 (8'hE1) for the default widths. No product exceeds that value, and no carry leaves the top of the merge adder.
- R7: The block holds no state. A change on the operands shows up on `prod_o` with no clock edge.
- R8: After each carry-save row j, the retired low bits plus the weighted sum and carry vectors equal `mcand_i` times the low j+1 bits of `mplier_i`. Carry-heavy operands such as all-ones times any value still give the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | MW | Unsigned multiplicand, broadcast along the array columns |
| mplier_i | input | NW | Unsigned multiplier; bit j drives array row j |
| prod_o | output | MW+NW | Unsigned product |

## Verification
Carries must travel diagonally, so the all-ones operands are the hardest case. A carry that was dropped or sent to the wrong weight would leave 15x15 below 225. It would also break the 15x7 and 7x15 pair in opposite ways. Zero operands and one-hot multipliers expose a partial product with the wrong weight: the result comes out doubled or halved instead of shifted. Sweeping all 256 pairs catches an edge cell wired as a half adder where three inputs meet, since some carry would then silently vanish. A check taken between clock edges shows that the output does not wait on any register.

// File: rtl/csm_pkg.sv
// Package: shared helpers for the carry-save array multiplier.
// Assumes: operand widths small enough that the product fits a longint.
package csm_pkg;

    // Largest unsigned product of an m-bit by n-bit operand pair.
    function automatic longint unsigned csm_max_product(input int m, input int n);
        longint unsigned a_max;
        longint unsigned b_max;
        a_max = (longint'(1) << m) - 1;
        b_max = (longint'(1) << n) - 1;
        return a_max * b_max;
    endfunction

    // Sum and carry of one adder cell, kept as a pair.
    typedef struct packed {
        logic c;
        logic s;
    } csm_sc_t;

endpackage

// File: rtl/csm_pp_gen.sv
// Module: csm_pp_gen
// Forms the AND-gate partial product matrix. Row j holds a[i] & b[j] at
// weight i+j. Assumes: purely combinational, every bit broadcast.
module csm_pp_gen #(
    parameter int MW = 4,
    parameter int NW = 4
) (
    input  logic [MW-1:0] a_i,
    input  logic [NW-1:0] b_i,
    output logic [MW-1:0] pp_o [NW]
);

    for (genvar j = 0; j < NW; j++) begin : g_row
        // One partial product row: multiplicand gated by multiplier bit j.
        assign pp_o[j] = a_i & {MW{b_i[j]}};
    end

endmodule

// File: rtl/csm_half_add.sv
// Module: csm_half_add
// Two-input adder cell, used where only two bits of a weight meet.
// Assumes: inputs are single bits of equal weight.
module csm_half_add (
    input  logic a_i,
    input  logic b_i,
    output logic s_o,
    output logic c_o
);

    import csm_pkg::*;

    csm_sc_t res;

    // Gate-level sum and carry of two bits.
    always_comb begin
        res.s = a_i ^ b_i;
        res.c = a_i & b_i;
    end

    assign s_o = res.s;
    assign c_o = res.c;

    // R8: the pair (c,s) counts the ones on the inputs.
    always_comb begin
        a_r8_ha_count: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("half adder count mismatch");
    end

endmodule

// File: rtl/csm_full_add.sv
// Module: csm_full_add
// Three-input adder cell of the carry-save rows and the merge adder.
// Assumes: inputs are single bits of equal weight.
module csm_full_add (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    import csm_pkg::*;

    csm_sc_t res;

    // Parity sum and majority carry of three bits.
    always_comb begin
        res.s = a_i ^ b_i ^ c_i;
        res.c = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end

    assign s_o = res.s;
    assign c_o = res.c;

    // R8: the pair (c,s) counts the ones on the inputs.
    always_comb begin
        a_r8_fa_count: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i}))
            else $error("full adder count mismatch");
    end

endmodule

// File: rtl/csm_merge_row.sv
// Module: csm_merge_row
// Vector-merging ripple adder. Adds the final sum vector (already aligned)
// and the final carry vector into W result bits. Assumes: the caller
// guarantees the exact product fits, so the carry out must be zero.
module csm_merge_row #(
    parameter int W = 4
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] car_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    logic [W:0] rc;

    assign rc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            // Lowest merge cell: no incoming ripple carry.
            csm_half_add u_ha (
                .a_i (sum_i[i]),
                .b_i (car_i[i]),
                .s_o (res_o[i]),
                .c_o (rc[i+1])
            );
        end else begin : g_mid
            // Ripple cell: aligned sum, saved carry and ripple carry.
            csm_full_add u_fa (
                .a_i (sum_i[i]),
                .b_i (car_i[i]),
                .c_i (rc[i]),
                .s_o (res_o[i]),
                .c_o (rc[i+1])
            );
        end
    end

    assign cout_o = rc[W];

endmodule

// File: rtl/csa_array_mult.sv
// Module: csa_array_mult
// Unsigned MW x NW carry-save array multiplier. Row 0 is the raw partial
// product row; rows 1..NW-1 are adder cells whose carries drop diagonally
// into the next row; a ripple merge adder resolves the top MW bits.
// Assumes: MW >= 2, NW >= 2, combinational use only (no clock, no reset).
module csa_array_mult #(
    parameter int MW = 4,
    parameter int NW = 4
) (
    input  logic [MW-1:0]    mcand_i,
    input  logic [NW-1:0]    mplier_i,
    output logic [MW+NW-1:0] prod_o
);

    import csm_pkg::*;

    localparam int PW = MW + NW;

    logic [MW-1:0] pp   [NW];
    logic [MW-1:0] sv   [NW];   // row sum vector, bit i at weight i+j
    logic [MW-1:0] cv   [NW];   // row carry vector, bit i at weight i+j+1
    logic [MW-1:0] m_sum;
    logic [MW-1:0] m_res;
    logic          m_cout;

    csm_pp_gen #(.MW(MW), .NW(NW)) u_pp (
        .a_i  (mcand_i),
        .b_i  (mplier_i),
        .pp_o (pp)
    );

    // Row 0 carries no adders: its sums are the raw partial products.
    assign sv[0] = pp[0];
    assign cv[0] = '0;

    for (genvar j = 1; j < NW; j++) begin : g_row
        for (genvar i = 0; i < MW; i++) begin : g_cell
            if (j == 1) begin : g_first
                // First array row: two inputs per weight at most.
                if (i < MW - 1) begin : g_in
                    csm_half_add u_ha (
                        .a_i (pp[j][i]),
                        .b_i (sv[j-1][i+1]),
                        .s_o (sv[j][i]),
                        .c_o (cv[j][i])
                    );
                end else begin : g_top
                    csm_half_add u_ha (
                        .a_i (pp[j][i]),
                        .b_i (1'b0),
                        .s_o (sv[j][i]),
                        .c_o (cv[j][i])
                    );
                end
            end else if (i < MW - 1) begin : g_body
                // Interior cell: partial product, shifted sum, saved carry.
                csm_full_add u_fa (
                    .a_i (pp[j][i]),
                    .b_i (sv[j-1][i+1]),
                    .c_i (cv[j-1][i]),
                    .s_o (sv[j][i]),
                    .c_o (cv[j][i])
                );
            end else begin : g_edge
                // Left edge: no sum arrives from above, so two inputs.
                csm_half_add u_ha (
                    .a_i (pp[j][i]),
                    .b_i (cv[j-1][i]),
                    .s_o (sv[j][i]),
                    .c_o (cv[j][i])
                );
            end
        end
    end

    for (genvar j = 0; j < NW; j++) begin : g_retire
        // Each row settles one low product bit.
        assign prod_o[j] = sv[j][0];
    end

    // Align the last row's sums onto the carry weights for merging.
    assign m_sum = {1'b0, sv[NW-1][MW-1:1]};

    csm_merge_row #(.W(MW)) u_merge (
        .sum_i  (m_sum),
        .car_i  (cv[NW-1]),
        .res_o  (m_res),
        .cout_o (m_cout)
    );

    assign prod_o[PW-1:NW] = m_res;

    // ---------------------------------------------------------------
    // Checks placed beside the array they guard.
    // ---------------------------------------------------------------

    // Weighted value held after row j: retired bits plus both vectors.
    function automatic longint unsigned row_held(
        input int               j,
        input logic [MW-1:0]    s_row,
        input logic [MW-1:0]    c_row,
        input logic [PW-1:0]    z
    );
        longint unsigned acc;
        acc = 0;
        for (int k = 0; k < j; k++) acc += longint'(z[k]) << k;
        for (int i = 0; i < MW; i++) begin
            acc += longint'(s_row[i]) << (i + j);
            acc += longint'(c_row[i]) << (i + j + 1);
        end
        return acc;
    endfunction

    // Multiplicand times the low j+1 multiplier bits.
    function automatic longint unsigned row_target(
        input int            j,
        input logic [MW-1:0] a,
        input logic [NW-1:0] b
    );
        longint unsigned acc;
        acc = 0;
        for (int k = 0; k <= j; k++)
            if (b[k]) acc += longint'(a) << k;
        return acc;
    endfunction

    always_comb begin
        // R8: carry-save invariant after every row.
        for (int j = 0; j < NW; j++) begin
            a_r8_row_invariant: assert (row_held(j, sv[j], cv[j], prod_o)
                                        == row_target(j, mcand_i, mplier_i))
                else $error("row %0d partial value wrong", j);
        end
        // R1: full product.
        a_r1_product: assert (prod_o == (PW'(mcand_i) * PW'(mplier_i)))
            else $error("product mismatch");
        // R2: a zero operand forces a zero product.
        a_r2_zero_operand: assert (!((mcand_i == '0) || (mplier_i == '0)) || (prod_o == '0))
            else $error("zero operand gave nonzero product");
        // R6: bounded result and no carry out of the merge adder.
        a_r6_no_overflow: assert ((m_cout == 1'b0)
                                  && (longint'(prod_o) <= csm_max_product(MW, NW)))
            else $error("merge adder overflow");
    end

endmodule

// File: tb/tb_csa_array_mult.sv
module tb_csa_array_mult;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0] x;
        logic [3:0] y;
        logic [7:0] z;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  4'd0,  8'd0},    // R2
        '{4'd0,  4'd15, 8'd0},    // R2
        '{4'd15, 4'd0,  8'd0},    // R2
        '{4'd1,  4'd13, 8'd13},   // R4
        '{4'd11, 4'd1,  8'd11},   // R4
        '{4'd15, 4'd15, 8'd225},  // R6
        '{4'd5,  4'd4,  8'd20},   // R5
        '{4'd9,  4'd8,  8'd72},   // R5
        '{4'd11, 4'd10, 8'd110},  // R1
        '{4'd15, 4'd7,  8'd105},  // R8
        '{4'd7,  4'd15, 8'd105},  // R8
        '{4'd13, 4'd11, 8'd143},  // R1
        '{4'd3,  4'd3,  8'd9}     // R3
    };

    logic       clk;
    logic [3:0] x;
    logic [3:0] y;
    logic [7:0] z;
    int         n_checks;
    int         n_fails;
    int         cycles;
    bit         done;

    csa_array_mult #(.MW(4), .NW(4)) dut (
        .mcand_i  (x),
        .mplier_i (y),
        .prod_o   (z)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s x=%0d y=%0d got=%0d expected=%0d", req, x, y, got, exp);
        end
    endtask

    // Drive operands on the falling edge and sample shortly after.
    task automatic apply(input logic [3:0] xa, input logic [3:0] ya);
        @(negedge clk);
        x = xa;
        y = ya;
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        cycles   = 0;
        done     = 1'b0;
        x = '0;
        y = '0;
        #1;
        // R2: idle operands at start give a zero product.
        check("R2 initial", z, 8'd0);

        // Table of directed vectors.
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].x, VECS[k].y);
            check("R1 table", z, VECS[k].z);
        end

        // R1: exhaustive sweep against the arithmetic product.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(4'(a), 4'(b));
                check("R1 sweep", z, 8'(a * b));
            end
        end

        // R5: one-hot multipliers shift the multiplicand.
        for (int k = 0; k < 4; k++) begin
            apply(4'd15, 4'(1 << k));
            check("R5 shift 15", z, 8'(15 << k));
            apply(4'd10, 4'(1 << k));
            check("R5 shift 10", z, 8'(10 << k));
        end

        // R3: lowest product bit is the AND of the operand LSBs.
        for (int k = 0; k < 4; k++) begin
            apply({3'b111, 1'(k & 1)}, {3'b101, 1'((k >> 1) & 1)});
            check("R3 lsb", {7'd0, z[0]}, {7'd0, 1'((k & 1) & ((k >> 1) & 1))});
        end

        // R4: identity in both operand positions.
        apply(4'd1, 4'd15);
        check("R4 one times", z, 8'd15);
        apply(4'd14, 4'd1);
        check("R4 times one", z, 8'd14);

        // R6: the largest product sets the top bit and no more.
        apply(4'd15, 4'd15);
        check("R6 max", z, 8'hE1);

        // R7: operand changes mid-cycle with no clock edge in between.
        @(posedge clk);
        #2;
        x = 4'd6;
        y = 4'd7;
        #1;
        check("R7 no clock", z, 8'd42);
        y = 4'd0;
        #1;
        check("R7 no clock", z, 8'd0);

        // R8: carry-heavy operands across every row.
        apply(4'd15, 4'd11);
        check("R8 carries", z, 8'd165);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule